// File: doc/BRIEF.md
# Shared-RAM Message Mailbox Controller

This block carries length-prefixed messages between a host CPU bus and an external serial co-processor. The messages sit in a single-port on-chip RAM that is divided into 256-byte pages. The CPU fills and reads that RAM directly. It steers the block through a five-entry register space: control, status, send trigger/flag, receive page and transmit page. The co-processor side has two byte-wide valid/ready streams and one data-ready level. A receive engine writes an incoming record into the selected receive page. A transmit engine streams a stored record out of the selected transmit page. There is no byte-by-byte data register. Each record starts with a length byte, and that many payload bytes follow it.

The CPU selects the register space or the RAM with `cpu_ram_sel`. A CPU access is one cycle wide on `cpu_req`, and read data appears on `cpu_rdata` in the following cycle. The CPU always wins the RAM port. The receive engine ranks above the transmit engine. An engine that loses simply waits one cycle. The RAM depth is a parameter; 8 KB uses `AW = 13`.

The receive engine has four states:
- RX_IDLE goes to RX_LEN when enable and data-ready are set and the received flag is clear.
- RX_LEN takes the length byte. It goes to RX_DONE if the length is zero, otherwise to RX_DATA.
- RX_DATA goes to RX_DONE on the last payload byte.
- RX_DONE sets the flag and returns to RX_IDLE.

The transmit engine has five states:
- TX_IDLE goes to TX_FETCH on a start.
- TX_FETCH goes to TX_LOAD once the RAM read is granted.
- TX_LOAD always goes to TX_SEND.
- TX_SEND goes to TX_DONE when the last byte is accepted, otherwise back to TX_FETCH.
- TX_DONE sets the sent flag and returns to TX_IDLE.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset, every register reads zero: enable, interrupt-enable, received, sent and both page indices. `irq`, `cp_tx_valid` and `cp_rx_ready` are low.
- R2: Offset 0 stores enable in bit 0 and interrupt-enable in bit 1. A read returns those two bits, and the other bits read zero.
- R3: Offset 1 reads the received flag in bit 7 and the live `cp_data_ready` input in bit 6. The other bits read zero.
- R4: A write of any value to offset 1 clears the received flag only while enable is set. With enable clear, the flag stays set.
- R5: Reception starts when enable and `cp_data_ready` are set and the received flag is clear. The length byte goes to page base = rx_page·256, and payload byte i goes to base+1+i. The received flag is set after the last byte. While the flag is set, `cp_rx_ready` stays low.
- R6: A write to offset 2 while enabled clears the sent flag. The block then streams the length byte at tx_page·256, followed by exactly that many payload bytes. The sent flag is set after the last byte is accepted. Offset 2 reads the sent flag in bit 7.
- R7: A write to offset 2 is ignored while enable is clear or while a transmission is running. It starts no transfer and leaves the sent flag alone.
- R8: Offsets 3 and 4 hold the 2-bit receive and transmit page indices (write bits 1:0, read back in bits 1:0). Each index is captured when a transfer starts.
- R9: `irq` is high exactly while interrupt-enable and the received flag are both set.
- R10: A CPU RAM access always takes the port in its cycle, and the CPU read data arrives the next cycle. An engine needing the port that cycle stalls: `cp_rx_ready` is low and no transmit read is issued.
- R11: A length byte of zero completes at once. On receive only the length byte is stored; on transmit only the length byte is sent.
- R12: While `cp_tx_valid` is high and `cp_tx_ready` is low, `cp_tx_valid` stays high and `cp_tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access strobe, one cycle per access |
| cpu_ram_sel | input | 1 | 1 = RAM, 0 = register space |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | RAM byte address, or register offset in bits 2:0 |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read |
| cp_data_ready | input | 1 | Co-processor has a message waiting |
| cp_rx_valid | input | 1 | Incoming byte valid |
| cp_rx_data | input | 8 | Incoming byte |
| cp_rx_ready | output | 1 | Block accepts the incoming byte |
| cp_tx_valid | output | 1 | Outgoing byte valid |
| cp_tx_data | output | 8 | Outgoing byte |
| cp_tx_ready | input | 1 | Co-processor accepts the outgoing byte |
| irq | output | 1 | Level interrupt: message received |

## Verification
A receive engine stuck in or out of a state shows up in one of two ways. Either `cp_rx_ready` is wrong within a cycle of the byte being offered, or the status bit 7 and `irq` are wrong a few cycles after the last byte. A miscounted length or page shows as wrong bytes when the CPU reads the page back, or as a wrong count or order on the transmit stream, where the scoreboard catches a missing or extra byte. Flag-handling faults, such as a clear while disabled or a start while busy, appear on the very next register read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_SEND = 3'd2;
    localparam logic [2:0] OFS_RXPG = 3'd3;
    localparam logic [2:0] OFS_TXPG = 3'd4;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_LEN,
        RX_DATA,
        RX_DONE
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_FETCH,
        TX_LOAD,
        TX_SEND,
        TX_DONE
    } tx_state_t;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    q
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end
            q <= mem[addr];
        end
    end
endmodule

// File: rtl/mbx_arb.sv
module mbx_arb #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic          rx_want,
    input  logic [AW-1:0] rx_addr,
    input  logic [7:0]    rx_wdata,
    input  logic          tx_want,
    input  logic [AW-1:0] tx_addr,
    output logic          rx_grant,
    output logic          tx_grant,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata
);
    // CPU first, then receive engine, then transmit engine
    assign rx_grant = !cpu_req;
    assign tx_grant = !cpu_req && !rx_want;

    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        if (cpu_req) begin
            ram_en    = 1'b1;
            ram_we    = cpu_we;
            ram_addr  = cpu_addr;
            ram_wdata = cpu_wdata;
        end else if (rx_want) begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = rx_addr;
            ram_wdata = rx_wdata;
        end else if (tx_want) begin
            ram_en    = 1'b1;
            ram_addr  = tx_addr;
        end
    end

    assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_req, rx_want && rx_grant, tx_want && tx_grant}));
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [2:0]        ofs,
    input  logic [7:0]        wdata,
    input  logic              set_received,
    input  logic              set_sent,
    input  logic              tx_busy,
    input  logic              cp_data_ready,
    output logic              en,
    output logic              ie,
    output logic              received,
    output logic [PAGE_W-1:0] rx_page,
    output logic [PAGE_W-1:0] tx_page,
    output logic              tx_start,
    output logic [7:0]        rdata
);
    logic sent;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[7:2];
    assign tx_start = wr && (ofs == OFS_SEND) && en && !tx_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            ie       <= 1'b0;
            received <= 1'b0;
            sent     <= 1'b0;
            rx_page  <= '0;
            tx_page  <= '0;
            rdata    <= '0;
        end else begin
            if (wr && ofs == OFS_CTRL) begin
                en <= wdata[0];
                ie <= wdata[1];
            end
            if (wr && ofs == OFS_RXPG) begin
                rx_page <= wdata[PAGE_W-1:0];
            end
            if (wr && ofs == OFS_TXPG) begin
                tx_page <= wdata[PAGE_W-1:0];
            end
            if (set_received) begin
                received <= 1'b1;
            end else if (wr && ofs == OFS_STAT && en) begin
                received <= 1'b0;
            end
            if (set_sent) begin
                sent <= 1'b1;
            end else if (tx_start) begin
                sent <= 1'b0;
            end
            if (rd) begin
                unique case (ofs)
                    OFS_CTRL: rdata <= {6'b0, ie, en};
                    OFS_STAT: rdata <= {received, cp_data_ready, 6'b0};
                    OFS_SEND: rdata <= {sent, 7'b0};
                    OFS_RXPG: rdata <= 8'(rx_page);
                    OFS_TXPG: rdata <= 8'(tx_page);
                    default:  rdata <= 8'h00;
                endcase
            end
        end
    end

    assert_rise_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(received) |-> $past(set_received));
    assert_keep_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ofs == OFS_STAT && !en && received) |=> received);
endmodule

// File: rtl/mbx_rx_engine.sv
module mbx_rx_engine
    import mbx_pkg::*;
#(
    parameter int AW     = 11,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              received,
    input  logic              cp_data_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              grant,
    input  logic [PAGE_W-1:0] page,
    output logic              rx_ready,
    output logic              want,
    output logic [AW-1:0]     addr,
    output logic [7:0]        wdata,
    output logic              set_received
);
    rx_state_t         st_q, st_d;
    logic [7:0]        ofs_q;
    logic [7:0]        remain_q;
    logic [PAGE_W-1:0] page_q;
    logic              taking;
    logic              accept;

    assign taking = (st_q == RX_LEN) || (st_q == RX_DATA);
    assign want   = rx_valid && taking;
    assign accept = want && grant;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE: if (en && cp_data_ready && !received) st_d = RX_LEN;
            RX_LEN:  if (accept) st_d = (rx_data == 8'd0) ? RX_DONE : RX_DATA;
            RX_DATA: if (accept && remain_q == 8'd1) st_d = RX_DONE;
            RX_DONE: st_d = RX_IDLE;
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q    <= '0;
            remain_q <= '0;
            page_q   <= '0;
        end else if (st_q == RX_IDLE) begin
            ofs_q  <= '0;
            page_q <= page;
        end else if (accept) begin
            ofs_q    <= ofs_q + 8'd1;
            remain_q <= (st_q == RX_LEN) ? rx_data : remain_q - 8'd1;
        end
    end

    always_comb begin
        rx_ready     = taking && grant;
        addr         = AW'({page_q, ofs_q});
        wdata        = rx_data;
        set_received = (st_q == RX_DONE);
    end

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_IDLE && received) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/mbx_tx_engine.sv
module mbx_tx_engine
    import mbx_pkg::*;
#(
    parameter int AW     = 11,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page,
    input  logic              grant,
    input  logic [7:0]        ram_q,
    input  logic              tx_ready,
    output logic              want,
    output logic [AW-1:0]     addr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              set_sent,
    output logic              busy
);
    tx_state_t         st_q, st_d;
    logic [7:0]        ofs_q;
    logic [7:0]        remain_q;
    logic [7:0]        byte_q;
    logic              first_q;
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (start) st_d = TX_FETCH;
            TX_FETCH: if (grant) st_d = TX_LOAD;
            TX_LOAD:  st_d = TX_SEND;
            TX_SEND:  if (tx_ready) st_d = (remain_q == 8'd0) ? TX_DONE : TX_FETCH;
            TX_DONE:  st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q    <= '0;
            remain_q <= '0;
            byte_q   <= '0;
            first_q  <= 1'b0;
            page_q   <= '0;
        end else begin
            if (st_q == TX_IDLE && start) begin
                ofs_q   <= '0;
                first_q <= 1'b1;
                page_q  <= page;
            end
            if (st_q == TX_LOAD) begin
                byte_q  <= ram_q;
                first_q <= 1'b0;
                remain_q <= first_q ? ram_q : remain_q - 8'd1;
            end
            if (st_q == TX_SEND && tx_ready) begin
                ofs_q <= ofs_q + 8'd1;
            end
        end
    end

    always_comb begin
        want     = (st_q == TX_FETCH);
        addr     = AW'({page_q, ofs_q});
        tx_valid = (st_q == TX_SEND);
        tx_data  = byte_q;
        set_sent = (st_q == TX_DONE);
        busy     = (st_q != TX_IDLE);
    end

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    assert_fetch_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_FETCH && !grant) |=> (st_q == TX_FETCH));
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int AW     = 11,
    parameter int PAGE_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_ram_sel,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    input  logic          cp_data_ready,
    input  logic          cp_rx_valid,
    input  logic [7:0]    cp_rx_data,
    output logic          cp_rx_ready,
    output logic          cp_tx_valid,
    output logic [7:0]    cp_tx_data,
    input  logic          cp_tx_ready,
    output logic          irq
);
    logic              cpu_ram_req, reg_wr, reg_rd;
    logic              en, ie, received, tx_start, tx_busy;
    logic              set_received, set_sent;
    logic [PAGE_W-1:0] rx_page, tx_page;
    logic [7:0]        reg_rdata, ram_q;
    logic              rx_want, rx_grant, tx_want, tx_grant;
    logic [AW-1:0]     rx_addr, tx_addr, ram_addr;
    logic [7:0]        rx_wdata, ram_wdata;
    logic              ram_en, ram_we;
    logic              last_ram_q;

    assign cpu_ram_req = cpu_req && cpu_ram_sel;
    assign reg_wr      = cpu_req && !cpu_ram_sel && cpu_we;
    assign reg_rd      = cpu_req && !cpu_ram_sel && !cpu_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ram_q <= 1'b0;
        end else if (cpu_req && !cpu_we) begin
            last_ram_q <= cpu_ram_sel;
        end
    end

    assign cpu_rdata = last_ram_q ? ram_q : reg_rdata;
    assign irq       = ie && received;

    mbx_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .ofs(cpu_addr[2:0]),
        .wdata(cpu_wdata), .set_received(set_received), .set_sent(set_sent),
        .tx_busy(tx_busy), .cp_data_ready(cp_data_ready), .en(en), .ie(ie),
        .received(received), .rx_page(rx_page), .tx_page(tx_page),
        .tx_start(tx_start), .rdata(reg_rdata)
    );

    mbx_rx_engine #(.AW(AW), .PAGE_W(PAGE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .received(received),
        .cp_data_ready(cp_data_ready), .rx_valid(cp_rx_valid), .rx_data(cp_rx_data),
        .grant(rx_grant), .page(rx_page), .rx_ready(cp_rx_ready), .want(rx_want),
        .addr(rx_addr), .wdata(rx_wdata), .set_received(set_received)
    );

    mbx_tx_engine #(.AW(AW), .PAGE_W(PAGE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .page(tx_page), .grant(tx_grant),
        .ram_q(ram_q), .tx_ready(cp_tx_ready), .want(tx_want), .addr(tx_addr),
        .tx_valid(cp_tx_valid), .tx_data(cp_tx_data), .set_sent(set_sent),
        .busy(tx_busy)
    );

    mbx_arb #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_ram_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rx_want(rx_want),
        .rx_addr(rx_addr), .rx_wdata(rx_wdata), .tx_want(tx_want), .tx_addr(tx_addr),
        .rx_grant(rx_grant), .tx_grant(tx_grant), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    mbx_ram #(.AW(AW)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
        .q(ram_q)
    );

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> received);
endmodule

// File: tb/sim_mbx_mailbox.sv
module sim_mbx_mailbox;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_ram_sel = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          cp_data_ready = 1'b0, cp_rx_valid = 1'b0;
    logic [7:0]    cp_rx_data = '0;
    logic          cp_rx_ready, cp_tx_valid, cp_tx_ready;
    logic [7:0]    cp_tx_data;
    logic          irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    int  rdy_mode = 1;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    mbx_mailbox #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ram_sel(cpu_ram_sel),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cp_data_ready(cp_data_ready),
        .cp_rx_valid(cp_rx_valid), .cp_rx_data(cp_rx_data), .cp_rx_ready(cp_rx_ready),
        .cp_tx_valid(cp_tx_valid), .cp_tx_data(cp_tx_data), .cp_tx_ready(cp_tx_ready),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // ready driver: 0 hold low, 1 hold high, 2 alternate
    initial begin
        cp_tx_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rdy_mode == 2) cp_tx_ready = ~cp_tx_ready;
            else cp_tx_ready = (rdy_mode == 1);
        end
    end

    // monitor / scoreboard
    logic       hold_pend = 1'b0;
    logic [7:0] hold_data = '0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (hold_pend) begin
                chk("R12 valid held", {7'b0, cp_tx_valid}, 8'h01);
                chk("R12 data held", cp_tx_data, hold_data);
            end
            hold_pend = cp_tx_valid && !cp_tx_ready;
            hold_data = cp_tx_data;
            if (cp_tx_valid && cp_tx_ready) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R6/R7 unexpected tx byte actual=%02h expected=none", cp_tx_data);
                end else begin
                    chk("R6 tx byte", cp_tx_data, exp_q.pop_front());
                end
            end
        end else begin
            hold_pend = 1'b0;
        end
    end

    task automatic cpu_wr(input logic ram, input int a, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_ram_sel = ram; cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic ram, input int a, output logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_ram_sel = ram; cpu_we = 1'b0; cpu_addr = AW'(a);
        @(negedge clk);
        cpu_req = 1'b0;
        #1 d = cpu_rdata;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        cp_rx_valid = 1'b1; cp_rx_data = b;
        #1;
        while (!cp_rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 cp_rx_valid = 1'b0;
    endtask

    task automatic wait_sent(input string tag);
        logic [7:0] v;
        logic seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            cpu_rd(1'b0, 2, v);
            seen = v[7];
        end
        chk(tag, {7'b0, seen}, 8'h01);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        wrap_up();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 tx_valid", {7'b0, cp_tx_valid}, 8'h00);
        chk("R1 rx_ready", {7'b0, cp_rx_ready}, 8'h00);
        for (int o = 0; o < 5; o++) begin
            cpu_rd(1'b0, o, v);
            chk("R1 register zero", v, 8'h00);
        end
        // R2 control
        cpu_wr(1'b0, 0, 8'hFC); cpu_rd(1'b0, 0, v); chk("R2 ctrl masked", v, 8'h00);
        cpu_wr(1'b0, 0, 8'h03); cpu_rd(1'b0, 0, v); chk("R2 ctrl both", v, 8'h03);
        // R8 pages
        cpu_wr(1'b0, 3, 8'hFD); cpu_rd(1'b0, 3, v); chk("R8 rx page", v, 8'h01);
        cpu_wr(1'b0, 4, 8'h06); cpu_rd(1'b0, 4, v); chk("R8 tx page", v, 8'h02);
        // R3 data-ready visible
        cpu_rd(1'b0, 1, v); chk("R3 status idle", v, 8'h00);

        // R6 transmit with backpressure
        cpu_wr(1'b1, 12'h200, 8'd3); cpu_wr(1'b1, 12'h201, 8'hA1);
        cpu_wr(1'b1, 12'h202, 8'hB2); cpu_wr(1'b1, 12'h203, 8'hC3);
        exp_q.push_back(8'd3); exp_q.push_back(8'hA1);
        exp_q.push_back(8'hB2); exp_q.push_back(8'hC3);
        rdy_mode = 2;
        cpu_wr(1'b0, 2, 8'h00);
        wait_sent("R6 sent set");
        repeat (10) @(negedge clk);
        chk("R6 all bytes out", 8'(exp_q.size()), 8'h00);

        // R11 zero-length transmit
        cpu_wr(1'b1, 12'h200, 8'd0);
        exp_q.push_back(8'd0);
        cpu_wr(1'b0, 2, 8'h00);
        wait_sent("R11 zero tx sent");
        repeat (10) @(negedge clk);
        chk("R11 only length byte", 8'(exp_q.size()), 8'h00);

        // R7 ignored while disabled
        cpu_wr(1'b0, 0, 8'h02);
        cpu_wr(1'b0, 2, 8'h00);
        repeat (30) @(negedge clk);
        cpu_rd(1'b0, 2, v); chk("R7 disabled keeps sent", v, 8'h80);

        // R7 ignored while busy, R6 sent cleared at start
        cpu_wr(1'b0, 0, 8'h01);
        cpu_wr(1'b1, 12'h200, 8'd5);
        exp_q.push_back(8'd5);
        for (int i = 1; i <= 5; i++) begin
            cpu_wr(1'b1, 12'h200 + i, 8'(8'h40 + i));
            exp_q.push_back(8'(8'h40 + i));
        end
        rdy_mode = 0;
        cpu_wr(1'b0, 2, 8'h00);
        cpu_rd(1'b0, 2, v); chk("R6 sent cleared at start", v, 8'h00);
        cpu_wr(1'b0, 2, 8'h00);
        rdy_mode = 1;
        wait_sent("R7 busy run sent");
        repeat (40) @(negedge clk);
        chk("R7 no second run", 8'(exp_q.size()), 8'h00);

        // R5 reception into page 1
        cpu_wr(1'b0, 0, 8'h03);
        cp_data_ready = 1'b1;
        rx_send(8'd3); rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
        repeat (3) @(negedge clk);
        cpu_rd(1'b0, 1, v); chk("R3 R5 received and ready", v, 8'hC0);
        chk("R9 irq high", {7'b0, irq}, 8'h01);
        cpu_rd(1'b1, 12'h100, v); chk("R5 length stored", v, 8'h03);
        cpu_rd(1'b1, 12'h101, v); chk("R5 payload 0", v, 8'h11);
        cpu_rd(1'b1, 12'h103, v); chk("R5 payload 2", v, 8'h33);
        // R5 no intake while flag set
        @(negedge clk);
        cp_rx_valid = 1'b1; cp_rx_data = 8'h77;
        for (int i = 0; i < 8; i++) begin
            #1 chk("R5 ready low while received", {7'b0, cp_rx_ready}, 8'h00);
            @(negedge clk);
        end
        cp_rx_valid = 1'b0;
        cpu_wr(1'b0, 0, 8'h01);
        #1 chk("R9 irq off without ie", {7'b0, irq}, 8'h00);
        // R4 clear only when enabled
        cpu_wr(1'b0, 0, 8'h00);
        cpu_wr(1'b0, 1, 8'h5A);
        cpu_rd(1'b0, 1, v); chk("R4 disabled no clear", v, 8'hC0);
        cpu_wr(1'b0, 0, 8'h01);
        cpu_wr(1'b0, 1, 8'h00);
        cpu_rd(1'b0, 1, v); chk("R4 cleared", v, 8'h40);

        // R11 zero-length receive
        rx_send(8'd0);
        repeat (3) @(negedge clk);
        cpu_rd(1'b0, 1, v); chk("R11 zero rx received", v, 8'hC0);
        cpu_rd(1'b1, 12'h100, v); chk("R11 length zero stored", v, 8'h00);
        cpu_rd(1'b1, 12'h101, v); chk("R11 payload untouched", v, 8'h11);

        // R10 CPU priority during reception into page 0
        cpu_wr(1'b1, 12'h300, 8'h5A);
        cpu_wr(1'b0, 3, 8'h00);
        cpu_wr(1'b0, 1, 8'h00);
        fork
            begin
                rx_send(8'd4); rx_send(8'hD1); rx_send(8'hD2);
                rx_send(8'hD3); rx_send(8'hD4);
            end
            begin
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    cpu_req = 1'b1; cpu_ram_sel = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(12'h300);
                    #1 chk("R10 rx stalls on cpu", {7'b0, cp_rx_ready}, 8'h00);
                    @(negedge clk);
                    cpu_req = 1'b0;
                    #1 chk("R10 cpu read data", cpu_rdata, 8'h5A);
                end
            end
        join
        repeat (3) @(negedge clk);
        cpu_rd(1'b0, 1, v); chk("R10 message complete", v, 8'hC0);
        cpu_rd(1'b1, 12'h000, v); chk("R10 length", v, 8'h04);
        cpu_rd(1'b1, 12'h001, v); chk("R10 first payload", v, 8'hD1);
        cpu_rd(1'b1, 12'h004, v); chk("R10 last payload", v, 8'hD4);

        // R1 reset clears flags and pages
        cpu_wr(1'b0, 3, 8'h02);
        cpu_wr(1'b0, 0, 8'h03);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        cp_data_ready = 1'b0;
        cpu_rd(1'b0, 0, v); chk("R1 reset ctrl", v, 8'h00);
        cpu_rd(1'b0, 1, v); chk("R1 reset received", v, 8'h00);
        cpu_rd(1'b0, 3, v); chk("R1 reset rx page", v, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);

        wrap_up();
    end
endmodule